// File: doc/BRIEF.md
# Static and Half-Duty LCD Drive Level Generator

This block turns a latched picture of 96 pixels into per-pin drive level codes for a passive LCD panel with 48 segment pins and two common (backplane) pins. On every frame tick it advances its drive sequence, and each output pin receives a 2-bit code that selects ground, half supply or full supply. An analog stage outside the block converts the codes into voltages. The block supports two drive schemes. In static drive a single backplane waveform serves all 48 segments. In half-duty drive the frame is split into two phases at half bias, so 48 segment pins address 96 pixels.

The polarity of the drive reverses in a fixed pattern, so each pixel sees zero average DC across a full sequence. Either common can be switched off by its own active-low enable, and a disabled common sits at ground. When blink is enabled, a slow blink clock blanks the panel. While that clock is high, every segment copies the active backplane level.

The pixel latch layout is as follows. Bit `2*i` is segment `i` against common A, and bit `2*i+1` is segment `i` against common B. Every output is registered, so a change at an input or at the internal sequence state appears on the pins one clock later.

Top module: `lcd_wave_gen`

## Requirements
- R1: While `rst` is high, every segment and common output is the ground code. The first output after reset reflects phase A with positive polarity.
- R2: The level codes are 2'b00 for ground, 2'b01 for half supply and 2'b10 for full supply. In static mode (`half_duty`=0), both commons carry the active backplane level. That level is full supply at positive polarity and ground at negative polarity, and it inverts on every frame tick.
- R3: In static mode, segment `i` uses pixel bit `2*i`. An on bit drives the level opposite to the active backplane level, and an off bit drives the same level.
- R4: In half-duty mode each frame tick advances the sequence A+, B+, A-, B-, A+, and so on: the phase alternates, and the polarity inverts when leaving phase B. Without a frame tick, the phase and polarity hold.
- R5: In half-duty mode the common of the current phase carries the active backplane level, and the other common carries half supply.
- R6: In half-duty mode, segment `i` uses bit `2*i` in phase A and bit `2*i+1` in phase B, with the same on/off rule as R3. A segment output never carries half supply.
- R7: When `com_a_en_n` or `com_b_en_n` is 1, the corresponding common output is the ground code. The segments are unaffected.
- R8: When `blink_en_n`=0 and `blink_clk`=1, all segments drive the active backplane level, which turns every pixel off. When `blink_en_n`=1, `blink_clk` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse that advances the drive sequence |
| half_duty | input | 1 | 1 selects half-duty drive, 0 selects static drive |
| pix_data | input | 2*NUM_SEG | Pixel latch; bit 2i is segment i on common A, bit 2i+1 is segment i on common B |
| blink_clk | input | 1 | Blink timing clock, used as a level |
| blink_en_n | input | 1 | Active-low blink enable |
| com_a_en_n | input | 1 | Active-low enable of common A |
| com_b_en_n | input | 1 | Active-low enable of common B |
| seg_lvl | output | 2*NUM_SEG | Level code of segment i at bits [2i+1:2i] |
| com_a_lvl | output | 2 | Level code of common A |
| com_b_lvl | output | 2 | Level code of common B |

## Verification
Several properties are checked on every cycle by the assertions:
- the sequencer steps through phase and polarity as R4 requires, and holds without a tick;
- no segment ever carries half supply;
- a disabled common is at ground;
- a blanked panel has all segments equal;
- in half-duty mode with both commons enabled, exactly one common sits at half supply.

The absolute expected levels can only be shown by the bench scenarios. These cover the mapping of each pixel bit to its segment in each phase, the exact polarity at each point of the sequence, the combinations of common disables, and blanking under every setting of the blink inputs. The bench sweeps every pixel pattern of a four-segment configuration through four frames in both modes.

// File: rtl/lcdw_pkg.sv
`timescale 1ns/1ps
package lcdw_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_GND  = 2'b00;
  localparam lvl_t LVL_HALF = 2'b01;
  localparam lvl_t LVL_FULL = 2'b10;

  // backplane level for a polarity: positive (0) is full supply
  function automatic lvl_t backplane_level(input logic neg_pol);
    return neg_pol ? LVL_GND : LVL_FULL;
  endfunction

  function automatic lvl_t invert_level(input lvl_t l);
    return (l == LVL_FULL) ? LVL_GND : LVL_FULL;
  endfunction
endpackage

// File: rtl/lcdw_sequencer.sv
`timescale 1ns/1ps
module lcdw_sequencer (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  input  logic half_duty,
  output logic phase_b,
  output logic neg_pol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_b <= 1'b0;
      neg_pol <= 1'b0;
    end else if (frame_tick) begin
      if (!half_duty) begin
        phase_b <= 1'b0;
        neg_pol <= ~neg_pol;
      end else begin
        phase_b <= ~phase_b;
        if (phase_b) neg_pol <= ~neg_pol;
      end
    end
  end

  assert_static_flip_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !half_duty) |=> (!phase_b && (neg_pol != $past(neg_pol))));
  assert_hd_a_to_b_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && half_duty && !phase_b) |=> (phase_b && $stable(neg_pol)));
  assert_hd_b_to_a_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && half_duty && phase_b) |=> (!phase_b && (neg_pol != $past(neg_pol))));
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> ($stable(phase_b) && $stable(neg_pol)));
endmodule

// File: rtl/lcdw_com_drive.sv
`timescale 1ns/1ps
module lcdw_com_drive
  import lcdw_pkg::*;
#(
  parameter bit IDX = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic half_duty,
  input  logic phase_b,
  input  lvl_t active_lvl,
  input  logic com_off,
  output lvl_t com_lvl
);
  lvl_t nxt;

  always_comb begin
    if (com_off)                  nxt = LVL_GND;
    else if (!half_duty)          nxt = active_lvl;
    else if (phase_b == IDX)      nxt = active_lvl;
    else                          nxt = LVL_HALF;
  end

  always_ff @(posedge clk) begin
    if (rst) com_lvl <= LVL_GND;
    else     com_lvl <= nxt;
  end

  assert_com_off_gnd_R7: assert property (@(posedge clk) disable iff (rst)
    com_off |=> (com_lvl == LVL_GND));
  assert_com_legal_R2: assert property (@(posedge clk) disable iff (rst)
    com_lvl != 2'b11);
endmodule

// File: rtl/lcdw_seg_drive.sv
`timescale 1ns/1ps
module lcdw_seg_drive
  import lcdw_pkg::*;
#(
  parameter int NUM_SEG = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*NUM_SEG-1:0] pix_data,
  input  logic                 half_duty,
  input  logic                 phase_b,
  input  lvl_t                 active_lvl,
  input  logic                 blank,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  localparam int PIX_W = 2 * NUM_SEG;

  logic use_b;
  lvl_t on_lvl;
  assign use_b  = half_duty & phase_b;
  assign on_lvl = invert_level(active_lvl);

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic pix_on;
    lvl_t nxt;
    assign pix_on = (use_b ? pix_data[2*i+1] : pix_data[2*i]) & ~blank;
    assign nxt    = pix_on ? on_lvl : active_lvl;

    always_ff @(posedge clk) begin
      if (rst) seg_lvl[2*i +: 2] <= LVL_GND;
      else     seg_lvl[2*i +: 2] <= nxt;
    end

    assert_seg_not_half_R6: assert property (@(posedge clk) disable iff (rst)
      (seg_lvl[2*i +: 2] == LVL_GND) || (seg_lvl[2*i +: 2] == LVL_FULL));
  end

  initial assert (PIX_W == 2 * NUM_SEG);
endmodule

// File: rtl/lcd_wave_gen.sv
`timescale 1ns/1ps
module lcd_wave_gen
  import lcdw_pkg::*;
#(
  parameter int NUM_SEG = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_tick,
  input  logic                 half_duty,
  input  logic [2*NUM_SEG-1:0] pix_data,
  input  logic                 blink_clk,
  input  logic                 blink_en_n,
  input  logic                 com_a_en_n,
  input  logic                 com_b_en_n,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [1:0]           com_a_lvl,
  output logic [1:0]           com_b_lvl
);
  localparam int NUM_COM = 2;

  logic phase_b, neg_pol, blank;
  lvl_t active_lvl;
  logic [NUM_COM-1:0] com_off;
  lvl_t com_lvl [NUM_COM];

  assign active_lvl = backplane_level(neg_pol);
  assign blank      = ~blink_en_n & blink_clk;
  assign com_off    = {com_b_en_n, com_a_en_n};

  lcdw_sequencer u_seq (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .half_duty(half_duty),
    .phase_b(phase_b), .neg_pol(neg_pol)
  );

  for (genvar g = 0; g < NUM_COM; g++) begin : g_com
    lcdw_com_drive #(.IDX(g == 1)) u_com (
      .clk(clk), .rst(rst), .half_duty(half_duty), .phase_b(phase_b),
      .active_lvl(active_lvl), .com_off(com_off[g]), .com_lvl(com_lvl[g])
    );
  end

  assign com_a_lvl = com_lvl[0];
  assign com_b_lvl = com_lvl[1];

  lcdw_seg_drive #(.NUM_SEG(NUM_SEG)) u_seg (
    .clk(clk), .rst(rst), .pix_data(pix_data), .half_duty(half_duty),
    .phase_b(phase_b), .active_lvl(active_lvl), .blank(blank),
    .seg_lvl(seg_lvl)
  );

  assert_blank_uniform_R8: assert property (@(posedge clk) disable iff (rst)
    blank |=> (seg_lvl == {NUM_SEG{seg_lvl[1:0]}}));
  assert_one_half_com_R5: assert property (@(posedge clk) disable iff (rst)
    (half_duty && !com_a_en_n && !com_b_en_n) |=>
      ((com_a_lvl == LVL_HALF) != (com_b_lvl == LVL_HALF)));
  assert_static_no_half_R2: assert property (@(posedge clk) disable iff (rst)
    !half_duty |=> (com_a_lvl != LVL_HALF) && (com_b_lvl != LVL_HALF));
endmodule

// File: tb/lcd_wave_gen_tb.sv
`timescale 1ns/1ps
module lcd_wave_gen_tb;
  localparam int NS = 4;
  localparam int PW = 2 * NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic half_duty = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic blink_clk = 1'b0;
  logic blink_en_n = 1'b1;
  logic com_a_en_n = 1'b0;
  logic com_b_en_n = 1'b0;
  logic [PW-1:0] seg_lvl;
  logic [1:0] com_a_lvl, com_b_lvl;

  int checks = 0;
  int errors = 0;
  logic m_ph = 1'b0;   // model phase (1 = B)
  logic m_pol = 1'b0;  // model polarity (1 = negative)

  always #4 clk = ~clk;

  lcd_wave_gen #(.NUM_SEG(NS)) u_dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .half_duty(half_duty),
    .pix_data(pix_data), .blink_clk(blink_clk), .blink_en_n(blink_en_n),
    .com_a_en_n(com_a_en_n), .com_b_en_n(com_b_en_n),
    .seg_lvl(seg_lvl), .com_a_lvl(com_a_lvl), .com_b_lvl(com_b_lvl)
  );

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string seg_tag, input string com_tag);
    logic [1:0] act_l, opp_l, ea, eb;
    logic [PW-1:0] es;
    logic blank;
    act_l = m_pol ? 2'b00 : 2'b10;
    opp_l = m_pol ? 2'b10 : 2'b00;
    blank = !blink_en_n && blink_clk;
    if (!half_duty) begin
      ea = act_l; eb = act_l;
    end else begin
      ea = m_ph ? 2'b01 : act_l;
      eb = m_ph ? act_l : 2'b01;
    end
    if (com_a_en_n) ea = 2'b00;
    if (com_b_en_n) eb = 2'b00;
    for (int i = 0; i < NS; i++) begin
      logic b;
      b = (half_duty && m_ph) ? pix_data[2*i+1] : pix_data[2*i];
      es[2*i +: 2] = (b && !blank) ? opp_l : act_l;
    end
    chk(seg_tag, seg_lvl, es);
    chk(com_tag, {{(PW-4){1'b0}}, com_a_lvl, com_b_lvl}, {{(PW-4){1'b0}}, ea, eb});
  endtask

  task automatic do_tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    if (!half_duty) begin
      m_ph = 1'b0; m_pol = ~m_pol;
    end else begin
      if (m_ph) m_pol = ~m_pol;
      m_ph = ~m_ph;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", seg_lvl, '0);
    chk("R1", {{(PW-4){1'b0}}, com_a_lvl, com_b_lvl}, '0);
    rst = 1'b0;
    @(negedge clk);
    compare("R1", "R1");

    // R2 R3 R4 R5 R6: sweep all patterns in both modes through four frames
    for (int hd = 0; hd < 2; hd++) begin
      half_duty = hd[0];
      for (int p = 0; p < (1 << PW); p++) begin
        pix_data = p[PW-1:0];
        @(negedge clk);
        if (hd == 0) compare("R3", "R2"); else compare("R6", "R5");
        for (int t = 0; t < 4; t++) begin
          do_tick();
          if (hd == 0) compare("R3", "R2"); else compare("R6", "R4");
        end
      end
    end

    // R4: no tick means no change
    half_duty = 1'b1;
    pix_data = 8'hA5;
    repeat (5) @(negedge clk);
    compare("R4", "R4");

    // R7: common disables in both modes
    for (int hd = 0; hd < 2; hd++) begin
      half_duty = hd[0];
      for (int d = 0; d < 4; d++) begin
        com_a_en_n = d[0];
        com_b_en_n = d[1];
        pix_data = 8'h3C ^ d[7:0];
        @(negedge clk);
        compare("R7", "R7");
        for (int t = 0; t < 4; t++) begin
          do_tick();
          compare("R7", "R7");
        end
      end
    end
    com_a_en_n = 1'b0;
    com_b_en_n = 1'b0;

    // R8: blink under every setting of its inputs
    for (int hd = 0; hd < 2; hd++) begin
      half_duty = hd[0];
      for (int bm = 0; bm < 4; bm++) begin
        blink_en_n = bm[0];
        blink_clk = bm[1];
        pix_data = 8'hFF;
        @(negedge clk);
        compare("R8", "R8");
        pix_data = 8'h96;
        for (int t = 0; t < 4; t++) begin
          do_tick();
          compare("R8", "R8");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule